// File: doc/BRIEF.md
# Processor Mode and Privilege Controller

This block holds the execution context of a small embedded CPU core. It tracks whether the core runs application code (thread mode) or services an exception (handler mode), whether the thread runs privileged or unprivileged, and which of two banked stack pointers, main or process, is in use. The effective privilege and the stack select are derived from both the mode and two control bits. Handler mode always runs privileged on the main stack. The only way for an unprivileged thread to become privileged again is to take an exception.

The core's decoder drives one-cycle event strobes into the block: exception entry, exception return with a 4-bit return code, special-register writes and reads addressed by a 3-bit selector, interrupt and fault mask commands, and an instruction barrier. A write that changes the stack select is held pending until the barrier arrives. All state changes take place on the rising clock edge. Register reads are combinational.

Top module: `mode_priv_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is in thread mode, privileged, on the main stack. Both stack pointers, both masks, the flags and the control bits are zero, and `ret_fault` is low.
- R2: In handler mode `privileged` is 1 and `psp_active` is 0, whatever the control bits hold.
- R3: In thread mode, control bit 0 = 1 makes `privileged` 0. The committed control bit 1 = 1 makes `psp_active` 1.
- R4: Special-register selectors are 0 = flags (bits 31:28 stored), 1 = control (bit 0 unprivileged, bit 1 stack select), 2 = main SP, 3 = process SP, 4 = interrupt mask (bit 0), 5 = fault mask (bit 0). Selectors 6 and 7 are ignored. When unprivileged, writes to any selector other than 0 have no effect.
- R5: Privileged code drops its privilege by writing 1 to control bit 0. Privilege returns only on an exception entry (`exc_entry`), which sets handler mode on the next edge.
- R6: An exception return code of 0x1 enters handler mode. Code 0x9 enters thread mode with the stack select cleared, and code 0xD enters thread mode with it set. Both codes take effect at once, with no barrier needed.
- R7: `mask_op` values are 1 = set interrupt mask, 2 = clear interrupt mask, 3 = set fault mask and 4 = clear fault mask. They have no effect when unprivileged.
- R8: A control write stores bit 1 as a pending select. The committed select takes the pending value only on a cycle with `isb` high.
- R9: Any other return code makes `ret_fault` high for exactly the cycle after the request and leaves all state unchanged.
- R10: A write to a stack pointer stores the data with bits 1:0 forced to zero.
- R11: `sr_rdata` is zero when `sr_rd` is low. When unprivileged, it is also zero for every selector other than 0. A control read returns the committed select in bit 1 and the unprivileged bit in bit 0.
- R12: When several events arrive in one cycle, only one of them acts, in this order of precedence: exception entry, exception return, register write, mask command, barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_entry | input | 1 | Exception taken strobe |
| exc_ret | input | 1 | Exception return strobe |
| exc_ret_code | input | 4 | Return code for exc_ret |
| sr_wr | input | 1 | Special-register write strobe |
| sr_rd | input | 1 | Special-register read enable |
| sr_sel | input | 3 | Special-register selector |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data (combinational) |
| mask_op | input | 3 | Mask command |
| isb | input | 1 | Instruction barrier strobe |
| handler_mode | output | 1 | 1 = handler mode |
| privileged | output | 1 | Effective privilege |
| psp_active | output | 1 | 1 = process stack active |
| msp_val | output | 32 | Main stack pointer |
| psp_val | output | 32 | Process stack pointer |
| primask | output | 1 | Interrupt mask bit |
| faultmask | output | 1 | Fault mask bit |
| ret_fault | output | 1 | Illegal return code pulse |

## Verification
Every state change, including the `ret_fault` pulse, appears one edge after the cycle that carries the event. The one exception is the stack select, which also needs a barrier cycle. `sr_rdata` is due in the same cycle, from the state held before the edge.

The bench drives inputs on the falling edge and checks `sr_rdata` just after driving. It then lets one rising edge pass and compares every other output at the next falling edge against a bench model advanced once per edge.

// File: rtl/mode_priv_ctrl.sv
module mode_priv_ctrl #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_entry,
  input  logic            exc_ret,
  input  logic [3:0]      exc_ret_code,
  input  logic            sr_wr,
  input  logic            sr_rd,
  input  logic [2:0]      sr_sel,
  input  logic [XLEN-1:0] sr_wdata,
  output logic [XLEN-1:0] sr_rdata,
  input  logic [2:0]      mask_op,
  input  logic            isb,
  output logic            handler_mode,
  output logic            privileged,
  output logic            psp_active,
  output logic [XLEN-1:0] msp_val,
  output logic [XLEN-1:0] psp_val,
  output logic            primask,
  output logic            faultmask,
  output logic            ret_fault
);
  localparam logic [3:0] RET_HND    = 4'h1;
  localparam logic [3:0] RET_THR_MS = 4'h9;
  localparam logic [3:0] RET_THR_PS = 4'hD;

  logic       hnd_q, npriv_q, spsel_q, spsel_pend_q;
  logic [3:0] flags_q;

  assign handler_mode = hnd_q;
  assign privileged   = hnd_q | ~npriv_q;
  assign psp_active   = ~hnd_q & spsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hnd_q        <= 1'b0;
      npriv_q      <= 1'b0;
      spsel_q      <= 1'b0;
      spsel_pend_q <= 1'b0;
      flags_q      <= '0;
      msp_val      <= '0;
      psp_val      <= '0;
      primask      <= 1'b0;
      faultmask    <= 1'b0;
      ret_fault    <= 1'b0;
    end else begin
      ret_fault <= 1'b0;
      if (exc_entry) begin
        hnd_q <= 1'b1;
      end else if (exc_ret) begin
        case (exc_ret_code)
          RET_HND:    hnd_q <= 1'b1;
          RET_THR_MS: begin hnd_q <= 1'b0; spsel_q <= 1'b0; spsel_pend_q <= 1'b0; end
          RET_THR_PS: begin hnd_q <= 1'b0; spsel_q <= 1'b1; spsel_pend_q <= 1'b1; end
          default:    ret_fault <= 1'b1;
        endcase
      end else if (sr_wr) begin
        if (sr_sel == 3'd0) begin
          flags_q <= sr_wdata[XLEN-1 -: 4];
        end else if (privileged) begin
          case (sr_sel)
            3'd1: begin npriv_q <= sr_wdata[0]; spsel_pend_q <= sr_wdata[1]; end
            3'd2: msp_val   <= {sr_wdata[XLEN-1:2], 2'b00};
            3'd3: psp_val   <= {sr_wdata[XLEN-1:2], 2'b00};
            3'd4: primask   <= sr_wdata[0];
            3'd5: faultmask <= sr_wdata[0];
            default: ;
          endcase
        end
      end else if (mask_op != 3'd0) begin
        if (privileged) begin
          case (mask_op)
            3'd1: primask   <= 1'b1;
            3'd2: primask   <= 1'b0;
            3'd3: faultmask <= 1'b1;
            3'd4: faultmask <= 1'b0;
            default: ;
          endcase
        end
      end else if (isb) begin
        spsel_q <= spsel_pend_q;
      end
    end
  end

  always_comb begin
    sr_rdata = '0;
    if (sr_rd) begin
      if (sr_sel == 3'd0) begin
        sr_rdata[XLEN-1 -: 4] = flags_q;
      end else if (privileged) begin
        case (sr_sel)
          3'd1: sr_rdata[1:0] = {spsel_q, npriv_q};
          3'd2: sr_rdata      = msp_val;
          3'd3: sr_rdata      = psp_val;
          3'd4: sr_rdata[0]   = primask;
          3'd5: sr_rdata[0]   = faultmask;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mode_priv_chk.sv
module mode_priv_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_entry,
  input logic            exc_ret,
  input logic [3:0]      exc_ret_code,
  input logic            sr_wr,
  input logic            isb,
  input logic            handler_mode,
  input logic            privileged,
  input logic            psp_active,
  input logic [XLEN-1:0] msp_val,
  input logic [XLEN-1:0] psp_val,
  input logic            primask,
  input logic            faultmask,
  input logic            ret_fault
);
  AST_HANDLER_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> (privileged && !psp_active)); // R2

  AST_PRIV_ONLY_VIA_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (privileged && !$past(privileged)) |-> handler_mode); // R5

  AST_HANDLER_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_mode && !$past(handler_mode)) |->
      ($past(exc_entry) || ($past(exc_ret) && $past(exc_ret_code) == 4'h1))); // R6

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !privileged |=> ($stable(primask) && $stable(faultmask))); // R7

  AST_SP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !privileged |=> ($stable(msp_val) && $stable(psp_val))); // R4

  AST_FAULT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fault |-> ($stable(handler_mode) && $stable(privileged) && $stable(psp_active))); // R9

  AST_SEL_NEEDS_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    (!handler_mode && !$past(handler_mode) && (psp_active != $past(psp_active)))
      |-> ($past(isb) || $past(exc_ret))); // R8

  AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (msp_val[1:0] == 2'b00) && (psp_val[1:0] == 2'b00)); // R10

  AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && sr_wr) |=> handler_mode); // R12
endmodule

bind mode_priv_ctrl mode_priv_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_entry(exc_entry), .exc_ret(exc_ret),
  .exc_ret_code(exc_ret_code), .sr_wr(sr_wr), .isb(isb),
  .handler_mode(handler_mode), .privileged(privileged), .psp_active(psp_active),
  .msp_val(msp_val), .psp_val(psp_val), .primask(primask),
  .faultmask(faultmask), .ret_fault(ret_fault)
);

// File: tb/sim_mode_priv_ctrl.sv
module sim_mode_priv_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_entry = 0, exc_ret = 0, sr_wr = 0, sr_rd = 0, isb = 0;
  logic [3:0] exc_ret_code = '0;
  logic [2:0] sr_sel = '0, mask_op = '0;
  logic [31:0] sr_wdata = '0, sr_rdata, msp_val, psp_val;
  logic handler_mode, privileged, psp_active, primask, faultmask, ret_fault;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mode_priv_ctrl u0 (.*);

  logic m_h, m_np, m_sp, m_pd, m_pm, m_fm, m_flt;
  logic [3:0] m_fl;
  logic [31:0] m_msp, m_psp;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic m_priv(); return m_h | ~m_np; endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    if (sr_rd) begin
      if (sr_sel == 0) r[31:28] = m_fl;
      else if (m_priv()) case (sr_sel)
        1: r[1:0] = {m_sp, m_np};
        2: r = m_msp;
        3: r = m_psp;
        4: r[0] = m_pm;
        5: r[0] = m_fm;
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic m_reset();
    {m_h, m_np, m_sp, m_pd, m_pm, m_fm, m_flt} = '0;
    m_fl = '0; m_msp = '0; m_psp = '0;
  endtask

  task automatic m_tick();
    logic p = m_priv();
    m_flt = 0;
    if (exc_entry) m_h = 1;
    else if (exc_ret) begin
      if (exc_ret_code == 4'h1) m_h = 1;
      else if (exc_ret_code == 4'h9) begin m_h = 0; m_sp = 0; m_pd = 0; end
      else if (exc_ret_code == 4'hD) begin m_h = 0; m_sp = 1; m_pd = 1; end
      else m_flt = 1;
    end else if (sr_wr) begin
      if (sr_sel == 0) m_fl = sr_wdata[31:28];
      else if (p) case (sr_sel)
        1: begin m_np = sr_wdata[0]; m_pd = sr_wdata[1]; end
        2: m_msp = sr_wdata & ~32'd3;
        3: m_psp = sr_wdata & ~32'd3;
        4: m_pm = sr_wdata[0];
        5: m_fm = sr_wdata[0];
        default: ;
      endcase
    end else if (mask_op != 0) begin
      if (p) case (mask_op)
        1: m_pm = 1; 2: m_pm = 0; 3: m_fm = 1; 4: m_fm = 0; default: ;
      endcase
    end else if (isb) m_sp = m_pd;
  endtask

  task automatic check_all(input string tag);
    chk("R6", {tag, " handler_mode"}, handler_mode, m_h);
    chk("R3", {tag, " privileged"}, privileged, m_priv());
    chk("R8", {tag, " psp_active"}, psp_active, ~m_h & m_sp);
    chk("R10", {tag, " msp_val"}, msp_val, m_msp);
    chk("R10", {tag, " psp_val"}, psp_val, m_psp);
    chk("R7", {tag, " primask"}, primask, m_pm);
    chk("R7", {tag, " faultmask"}, faultmask, m_fm);
    chk("R9", {tag, " ret_fault"}, ret_fault, m_flt);
  endtask

  task automatic clear_in();
    exc_entry = 0; exc_ret = 0; sr_wr = 0; sr_rd = 0; isb = 0; mask_op = 0;
  endtask

  // inputs already set at negedge; check read, advance one edge, check state
  task automatic step(input string tag);
    #1 chk("R11", {tag, " sr_rdata"}, sr_rdata, exp_rd());
    @(posedge clk); m_tick();
    @(negedge clk); check_all(tag);
    clear_in();
  endtask

  task automatic do_wr(input logic [2:0] s, input logic [31:0] d, input string tag);
    sr_wr = 1; sr_sel = s; sr_wdata = d; step(tag);
  endtask
  task automatic do_ret(input logic [3:0] c, input string tag);
    exc_ret = 1; exc_ret_code = c; step(tag);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after reset");
    sr_rd = 1; sr_sel = 1; step("R1 control read");

    do_wr(2, 32'hDEAD_BEEF, "R10 msp align");
    do_wr(3, 32'h1234_5677, "R10 psp align");
    do_wr(1, 32'h2, "R8 pending select");
    chk("R8", "select before barrier", psp_active, 1'b0);
    isb = 1; step("R8 barrier");
    chk("R3", "psp after barrier", psp_active, 1'b1);
    mask_op = 1; step("R7 set pm");
    mask_op = 3; step("R7 set fm");
    do_wr(1, 32'h3, "R5 drop privilege");
    chk("R5", "unprivileged", privileged, 1'b0);
    do_wr(2, 32'h0000_1000, "R4 ignored msp write");
    do_wr(1, 32'h0, "R4 ignored control write");
    chk("R4", "still unprivileged", privileged, 1'b0);
    do_wr(0, 32'hA000_0000, "R4 flags write allowed");
    mask_op = 2; step("R7 ignored clear");
    chk("R7", "pm held", primask, 1'b1);
    sr_rd = 1; sr_sel = 2; step("R11 restricted read zero");
    sr_rd = 1; sr_sel = 0; step("R11 flags read");
    exc_entry = 1; step("R5 exception entry");
    chk("R2", "handler priv", privileged, 1'b1);
    chk("R2", "handler msp", psp_active, 1'b0);
    do_ret(4'h7, "R9 bad code");
    chk("R9", "fault pulse", ret_fault, 1'b1);
    @(negedge clk); chk("R9", "fault one cycle", ret_fault, 1'b0);
    do_ret(4'h1, "R6 nested return");
    do_ret(4'h9, "R6 thread msp");
    do_ret(4'hD, "R6 thread psp");
    exc_entry = 1; sr_wr = 1; sr_sel = 2; sr_wdata = 32'h40; step("R12 entry over write");
    chk("R12", "msp unchanged", msp_val, m_msp);
    exc_ret = 1; exc_ret_code = 4'h9; isb = 1; mask_op = 2; step("R12 return over mask");

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom % 8;
      sr_rd = $urandom % 2; sr_sel = 3'($urandom);
      case (op)
        0: exc_entry = ($urandom % 4 == 0);
        1: begin
          int k = $urandom % 4;
          exc_ret = 1;
          exc_ret_code = (k == 0) ? 4'h1 : (k == 1) ? 4'h9 : (k == 2) ? 4'hD : 4'($urandom);
        end
        2, 3: begin sr_wr = 1; sr_wdata = $urandom; end
        4: mask_op = 3'(1 + $urandom % 4);
        5: isb = 1;
        default: ;
      endcase
      step("R12 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule